// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside one flash array and watches every byte write and read that the host makes to it. It recognises the coded command sequences that a host must issue before the array will program or erase. Each sequence opens with a two-write unlock prefix on fixed low addresses. A third write then chooses the operation. When a sequence completes, the block raises a single one-clock request toward the program/erase engine. The request carries the target address and data, or the set of sectors involved. The engine and the storage array are outside this block.

Sector erase takes a variable number of confirmations. Each confirming write to a further sector must arrive within a rolling window measured in microsecond ticks. The erase request is issued once that window closes with no further confirmation. The block also answers the identifier and protection reads that are allowed in query mode. A wrong byte, a wrong address, a write with no sector selected, or too long a gap between writes drops the sequence and returns the decoder to read-array mode.

Top module: `fcmd_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises, every request output and `rd_vld` are 0. A reset in the middle of a sequence discards the sequence.
- R2: The writes AAh@555h, 55h@AAAh and A0h@555h, followed by a write of D to address A in a sector that is not protected, produce one `req_prog` pulse with `req_addr`=A, `req_data`=D and `req_sectors`=`sec_sel` at that write.
- R3: Only `addr_lo[11:0]` is decoded, and it must equal 555h or AAAh exactly. A prefix write with the wrong byte or the wrong address drops the sequence, so the writes that follow produce no request.
- R4: The writes AAh@555h, 55h@AAAh and 90h@555h produce one `req_query` pulse and enter query mode.
- R5: In query mode, a read with a sector selected returns data on `rd_vld` two clocks after `rd_en`. When `addr_lo` bits 6,1,0 are 0,0,1 the data is E7h. When they are 0,1,0 the data is 01h if a selected sector is protected and 00h if not. Other addresses give no `rd_vld`.
- R6: The writes AAh@555h, 55h@AAAh, 80h@555h, AAh@555h, 55h@AAAh and 10h@555h produce one `req_bulk` pulse with `req_sectors` equal to the unprotected sectors. Bit i of `req_sectors` stands for sector i.
- R7: The same erase prefix followed by 30h written inside a sector starts a sector erase. One `req_sect` pulse follows once WIN_US ticks pass with no further write. Its `req_sectors` holds the confirmed sectors minus the protected ones.
- R8: A further 30h write to another sector, arriving before the window closes, adds that sector and restarts the window. A 30h write after the request has been issued adds nothing and aborts.
- R9: After a sector erase request, B0h gives one `req_susp` pulse. While suspended, 30h gives one `req_resume` pulse. B0h has no effect in read-array mode.
- R10: F0h written with a sector selected gives one `req_reset` pulse in any state and returns the decoder to read-array mode. After it, query reads give no `rd_vld`.
- R11: If TMO_US ticks pass between two writes of an unfinished sequence, the sequence is dropped. A gap shorter than that keeps the sequence alive.
- R12: A write with no sector selected drops the sequence. A program, or an erase that would touch only protected sectors, produces no request.
- R13: At most one request output is high in any cycle. Each request lasts one clock, and a request caused by a write appears two clocks after that write's strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_lo | input | 12 | Low host address bits of the access |
| sec_sel | input | NSEC | Active sector select, one-hot or zero |
| sec_prot | input | NSEC | Per-sector write protection, 1 = protected |
| wdata | input | 8 | Host write byte |
| wr_en | input | 1 | One-clock write strobe |
| rd_en | input | 1 | One-clock read strobe |
| us_tick | input | 1 | One-clock pulse per microsecond |
| req_prog | output | 1 | Program-byte request |
| req_bulk | output | 1 | Bulk-erase request |
| req_sect | output | 1 | Sector-erase request |
| req_susp | output | 1 | Erase-suspend request |
| req_resume | output | 1 | Erase-resume request |
| req_reset | output | 1 | Return-to-read-array request |
| req_query | output | 1 | Query-mode entry request |
| req_addr | output | 12 | Program target address |
| req_data | output | 8 | Program data byte |
| req_sectors | output | NSEC | Sectors a request applies to |
| rd_data | output | 8 | Query read data |
| rd_vld | output | 1 | Query read data valid |

## Verification
The bench goes after the boundaries where a decoder typically errs:
- an unlock write one address off, or with a neighbouring data byte, which a loose decoder would accept and then program anyway;
- a write with no sector selected mid-prefix;
- a gap of just under the timeout, which must survive, and one just over, which must not;
- an erase confirmation after the window has closed, which a design that never closes the window would fold into a second erase.

It also checks that erases aimed only at protected sectors produce no request at all, not an empty one. It checks that suspend outside an erase and reads at non-query addresses stay silent. Finally, it checks that a reset in the middle of a sequence cannot let the final write complete it.

// File: rtl/fcmd_pkg.sv
// Package: shared constants and types for the flash command sequence decoder.
// Assumes 8-bit command bytes and 12 decoded low address bits.
package fcmd_pkg;

    localparam logic [11:0] UNLOCK_LO = 12'h555;
    localparam logic [11:0] UNLOCK_HI = 12'hAAA;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] CMD_QUERY  = 8'h90;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_BULK   = 8'h10;
    localparam logic [7:0] CMD_SECT   = 8'h30;
    localparam logic [7:0] CMD_SUSP   = 8'hB0;
    localparam logic [7:0] CMD_RESET  = 8'hF0;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PGM,
        ST_ERA0,
        ST_ERA1,
        ST_ERA2,
        ST_COLLECT,
        ST_ERASING,
        ST_SUSP,
        ST_QUERY
    } seq_state_e;

    typedef struct packed {
        logic qry;
        logic rst;
        logic resume;
        logic susp;
        logic sect;
        logic bulk;
        logic prog;
    } req_set_t;

endpackage

// File: rtl/fcmd_bus_qual.sv
// Module: registers one host access and pre-classifies its low address.
// Assumes wr_en and rd_en are single-clock strobes; adds one clock of latency.
module fcmd_bus_qual
    import fcmd_pkg::*;
#(
    parameter int NSEC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     addr_lo,
    input  logic [NSEC-1:0] sec_sel,
    input  logic [7:0]      wdata,
    input  logic            wr_en,
    input  logic            rd_en,
    output logic            wev_vld,
    output logic            rev_vld,
    output logic [11:0]     ev_addr,
    output logic [7:0]      ev_data,
    output logic [NSEC-1:0] ev_sel,
    output logic            ev_at_lo,
    output logic            ev_at_hi
);

    // Capture the access and the unlock-address matches in one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wev_vld  <= 1'b0;
            rev_vld  <= 1'b0;
            ev_addr  <= '0;
            ev_data  <= '0;
            ev_sel   <= '0;
            ev_at_lo <= 1'b0;
            ev_at_hi <= 1'b0;
        end else begin
            wev_vld  <= wr_en;
            rev_vld  <= rd_en & ~wr_en;
            ev_addr  <= addr_lo;
            ev_data  <= wdata;
            ev_sel   <= sec_sel;
            ev_at_lo <= (addr_lo == UNLOCK_LO);
            ev_at_hi <= (addr_lo == UNLOCK_HI);
        end
    end

endmodule

// File: rtl/fcmd_us_timer.sv
// Module: saturating microsecond counter restarted by every write event.
// Assumes us_tick is a one-clock pulse; reports when either limit is reached.
module fcmd_us_timer #(
    parameter int TMO_US = 100,
    parameter int WIN_US = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic us_tick,
    output logic tmo_hit,
    output logic win_hit
);

    localparam int CNT_MAX = (TMO_US > WIN_US) ? TMO_US : WIN_US;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] MAX_C = CW'(CNT_MAX);
    localparam logic [CW-1:0] TMO_C = CW'(TMO_US);
    localparam logic [CW-1:0] WIN_C = CW'(WIN_US);

    logic [CW-1:0] cnt;

    // Count ticks since the last write, holding at the larger limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (us_tick && (cnt != MAX_C)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Compare the elapsed count against both limits.
    always_comb begin
        tmo_hit = (cnt >= TMO_C);
        win_hit = (cnt >= WIN_C);
    end

endmodule

// File: rtl/fcmd_seq_fsm.sv
// Module: command sequence state machine; turns qualified writes into requests.
// Assumes events arrive from fcmd_bus_qual and timer levels from fcmd_us_timer.
module fcmd_seq_fsm
    import fcmd_pkg::*;
#(
    parameter int NSEC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wev_vld,
    input  logic [11:0]     ev_addr,
    input  logic [7:0]      ev_data,
    input  logic [NSEC-1:0] ev_sel,
    input  logic            ev_at_lo,
    input  logic            ev_at_hi,
    input  logic [NSEC-1:0] sec_prot,
    input  logic            tmo_hit,
    input  logic            win_hit,
    output req_set_t        req,
    output logic [11:0]     req_addr,
    output logic [7:0]      req_data,
    output logic [NSEC-1:0] req_sectors,
    output logic            qry_mode
);

    seq_state_e      st, st_n;
    logic [NSEC-1:0] set_q, set_n;
    req_set_t        req_n;
    logic [11:0]     addr_n;
    logic [7:0]      data_n;
    logic [NSEC-1:0] secs_n;
    logic [NSEC-1:0] eff_collect;
    logic [NSEC-1:0] eff_bulk;
    logic            sel_ok;
    logic            timed;

    // Decode helper terms shared by the next-state logic.
    always_comb begin
        sel_ok      = |ev_sel;
        eff_collect = set_q & ~sec_prot;
        eff_bulk    = ~sec_prot;
        timed       = (st == ST_UNL1) || (st == ST_UNL2) || (st == ST_PGM) ||
                      (st == ST_ERA0) || (st == ST_ERA1) || (st == ST_ERA2);
    end

    // Next state, accumulated sector set and request selection.
    always_comb begin
        st_n   = st;
        set_n  = set_q;
        req_n  = '0;
        addr_n = req_addr;
        data_n = req_data;
        secs_n = req_sectors;
        if (timed && tmo_hit) begin
            st_n = ST_READ;
        end else if ((st == ST_COLLECT) && win_hit && !wev_vld) begin
            if (|eff_collect) begin
                req_n.sect = 1'b1;
                secs_n     = eff_collect;
                st_n       = ST_ERASING;
            end else begin
                st_n = ST_READ;
            end
        end else if (wev_vld) begin
            if (sel_ok && (ev_data == CMD_RESET)) begin
                req_n.rst = 1'b1;
                st_n      = ST_READ;
            end else if (!sel_ok) begin
                st_n = ST_READ;
            end else begin
                unique case (st)
                    ST_READ: begin
                        if (ev_at_lo && (ev_data == KEY_FIRST)) st_n = ST_UNL1;
                    end
                    ST_UNL1: begin
                        st_n = (ev_at_hi && (ev_data == KEY_SECOND)) ? ST_UNL2 : ST_READ;
                    end
                    ST_UNL2: begin
                        st_n = ST_READ;
                        if (ev_at_lo) begin
                            if (ev_data == CMD_QUERY) begin
                                req_n.qry = 1'b1;
                                st_n      = ST_QUERY;
                            end else if (ev_data == CMD_PROG) begin
                                st_n = ST_PGM;
                            end else if (ev_data == CMD_ERASE) begin
                                st_n = ST_ERA0;
                            end
                        end
                    end
                    ST_PGM: begin
                        st_n = ST_READ;
                        if (|(ev_sel & ~sec_prot)) begin
                            req_n.prog = 1'b1;
                            addr_n     = ev_addr;
                            data_n     = ev_data;
                            secs_n     = ev_sel;
                        end
                    end
                    ST_ERA0: begin
                        st_n = (ev_at_lo && (ev_data == KEY_FIRST)) ? ST_ERA1 : ST_READ;
                    end
                    ST_ERA1: begin
                        st_n = (ev_at_hi && (ev_data == KEY_SECOND)) ? ST_ERA2 : ST_READ;
                    end
                    ST_ERA2: begin
                        st_n = ST_READ;
                        if (ev_at_lo && (ev_data == CMD_BULK)) begin
                            if (|eff_bulk) begin
                                req_n.bulk = 1'b1;
                                secs_n     = eff_bulk;
                            end
                        end else if (ev_data == CMD_SECT) begin
                            set_n = ev_sel;
                            st_n  = ST_COLLECT;
                        end
                    end
                    ST_COLLECT: begin
                        if (ev_data == CMD_SECT) begin
                            set_n = set_q | ev_sel;
                        end else begin
                            st_n = ST_READ;
                        end
                    end
                    ST_ERASING: begin
                        if (ev_data == CMD_SUSP) begin
                            req_n.susp = 1'b1;
                            st_n       = ST_SUSP;
                        end else begin
                            st_n = ST_READ;
                        end
                    end
                    ST_SUSP: begin
                        if (ev_data == CMD_SECT) begin
                            req_n.resume = 1'b1;
                            st_n         = ST_ERASING;
                        end else begin
                            st_n = ST_READ;
                        end
                    end
                    ST_QUERY: begin
                        st_n = ST_READ;
                    end
                    default: begin
                        st_n = ST_READ;
                    end
                endcase
            end
        end
    end

    // Register state, sector set and the request outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_READ;
            set_q       <= '0;
            req         <= '0;
            req_addr    <= '0;
            req_data    <= '0;
            req_sectors <= '0;
        end else begin
            st          <= st_n;
            set_q       <= set_n;
            req         <= req_n;
            req_addr    <= addr_n;
            req_data    <= data_n;
            req_sectors <= secs_n;
        end
    end

    // Expose query mode to the read responder.
    always_comb qry_mode = (st == ST_QUERY);

endmodule

// File: rtl/fcmd_query_rd.sv
// Module: answers identifier and protection reads while in query mode.
// Assumes the read event is already registered; adds one further clock.
module fcmd_query_rd #(
    parameter int         NSEC    = 8,
    parameter logic [7:0] ID_BYTE = 8'hE7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rev_vld,
    input  logic            qry_mode,
    input  logic [2:0]      qsel,
    input  logic [NSEC-1:0] ev_sel,
    input  logic [NSEC-1:0] sec_prot,
    output logic [7:0]      rd_data,
    output logic            rd_vld
);

    logic want_id;
    logic want_prot;
    logic hit_prot;

    // Decode the query address bits (6,1,0) and protection of the selection.
    always_comb begin
        want_id   = (qsel == 3'b001);
        want_prot = (qsel == 3'b010);
        hit_prot  = |(ev_sel & sec_prot);
    end

    // Register the query response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_vld  <= rev_vld && qry_mode && (|ev_sel) && (want_id || want_prot);
            rd_data <= want_id ? ID_BYTE : {7'd0, hit_prot};
        end
    end

endmodule

// File: rtl/fcmd_decoder.sv
// Module: top of the flash command sequence decoder.
// Assumes one host access per strobe and a free-running microsecond tick.
module fcmd_decoder
    import fcmd_pkg::*;
#(
    parameter int         NSEC    = 8,
    parameter int         TMO_US  = 100,
    parameter int         WIN_US  = 80,
    parameter logic [7:0] ID_BYTE = 8'hE7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     addr_lo,
    input  logic [NSEC-1:0] sec_sel,
    input  logic [NSEC-1:0] sec_prot,
    input  logic [7:0]      wdata,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic            us_tick,
    output logic            req_prog,
    output logic            req_bulk,
    output logic            req_sect,
    output logic            req_susp,
    output logic            req_resume,
    output logic            req_reset,
    output logic            req_query,
    output logic [11:0]     req_addr,
    output logic [7:0]      req_data,
    output logic [NSEC-1:0] req_sectors,
    output logic [7:0]      rd_data,
    output logic            rd_vld
);

    logic            wev_vld;
    logic            rev_vld;
    logic [11:0]     ev_addr;
    logic [7:0]      ev_data;
    logic [NSEC-1:0] ev_sel;
    logic            ev_at_lo;
    logic            ev_at_hi;
    logic            tmo_hit;
    logic            win_hit;
    logic            qry_mode;
    req_set_t        req;

    fcmd_bus_qual #(.NSEC(NSEC)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_lo  (addr_lo),
        .sec_sel  (sec_sel),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wev_vld  (wev_vld),
        .rev_vld  (rev_vld),
        .ev_addr  (ev_addr),
        .ev_data  (ev_data),
        .ev_sel   (ev_sel),
        .ev_at_lo (ev_at_lo),
        .ev_at_hi (ev_at_hi)
    );

    fcmd_us_timer #(.TMO_US(TMO_US), .WIN_US(WIN_US)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (wev_vld),
        .us_tick (us_tick),
        .tmo_hit (tmo_hit),
        .win_hit (win_hit)
    );

    fcmd_seq_fsm #(.NSEC(NSEC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wev_vld     (wev_vld),
        .ev_addr     (ev_addr),
        .ev_data     (ev_data),
        .ev_sel      (ev_sel),
        .ev_at_lo    (ev_at_lo),
        .ev_at_hi    (ev_at_hi),
        .sec_prot    (sec_prot),
        .tmo_hit     (tmo_hit),
        .win_hit     (win_hit),
        .req         (req),
        .req_addr    (req_addr),
        .req_data    (req_data),
        .req_sectors (req_sectors),
        .qry_mode    (qry_mode)
    );

    fcmd_query_rd #(.NSEC(NSEC), .ID_BYTE(ID_BYTE)) u_qry (
        .clk      (clk),
        .rst_n    (rst_n),
        .rev_vld  (rev_vld),
        .qry_mode (qry_mode),
        .qsel     ({ev_addr[6], ev_addr[1], ev_addr[0]}),
        .ev_sel   (ev_sel),
        .sec_prot (sec_prot),
        .rd_data  (rd_data),
        .rd_vld   (rd_vld)
    );

    // Unpack the request set onto the named outputs.
    always_comb begin
        req_prog   = req.prog;
        req_bulk   = req.bulk;
        req_sect   = req.sect;
        req_susp   = req.susp;
        req_resume = req.resume;
        req_reset  = req.rst;
        req_query  = req.qry;
    end

endmodule

// File: rtl/fcmd_decoder_chk.sv
// Module: property checker for fcmd_decoder, attached by bind below.
// Assumes it sees only the top-level ports.
module fcmd_decoder_chk #(
    parameter int         NSEC    = 8,
    parameter logic [7:0] ID_BYTE = 8'hE7
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSEC-1:0] sec_prot,
    input logic            wr_en,
    input logic            rd_en,
    input logic            req_prog,
    input logic            req_bulk,
    input logic            req_sect,
    input logic            req_susp,
    input logic            req_resume,
    input logic            req_reset,
    input logic            req_query,
    input logic [NSEC-1:0] req_sectors,
    input logic [7:0]      rd_data,
    input logic            rd_vld
);

    // R13
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_prog, req_bulk, req_sect, req_susp, req_resume, req_reset, req_query}));

    // R13
    prog_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_prog |=> !req_prog);

    // R13
    sect_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_sect |=> !req_sect);

    // R13
    req_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_prog || req_bulk || req_susp || req_resume || req_reset || req_query)
        |-> $past(wr_en, 2));

    // R5
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> $past(rd_en, 2));

    // R5
    rd_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> ((rd_data == ID_BYTE) || (rd_data == 8'h00) || (rd_data == 8'h01)));

    // R12
    sect_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_sect |-> ((|req_sectors) && ((req_sectors & $past(sec_prot)) == '0)));

    // R6
    bulk_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_bulk |-> ((|req_sectors) && ((req_sectors & $past(sec_prot)) == '0)));

endmodule

bind fcmd_decoder fcmd_decoder_chk #(.NSEC(NSEC), .ID_BYTE(ID_BYTE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_prot    (sec_prot),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .req_prog    (req_prog),
    .req_bulk    (req_bulk),
    .req_sect    (req_sect),
    .req_susp    (req_susp),
    .req_resume  (req_resume),
    .req_reset   (req_reset),
    .req_query   (req_query),
    .req_sectors (req_sectors),
    .rd_data     (rd_data),
    .rd_vld      (rd_vld)
);

// File: tb/fcmd_decoder_tb.sv
`timescale 1ns/1ps
module fcmd_decoder_tb;

    localparam int TICK_DIV = 4;

    localparam logic [1:0] OP_W = 2'd0;
    localparam logic [1:0] OP_R = 2'd1;
    localparam logic [1:0] OP_D = 2'd2;

    localparam logic [2:0] RQ_N  = 3'd0;
    localparam logic [2:0] RQ_PG = 3'd1;
    localparam logic [2:0] RQ_BK = 3'd2;
    localparam logic [2:0] RQ_SE = 3'd3;
    localparam logic [2:0] RQ_SU = 3'd4;
    localparam logic [2:0] RQ_RS = 3'd5;
    localparam logic [2:0] RQ_RT = 3'd6;
    localparam logic [2:0] RQ_QY = 3'd7;

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [7:0]  data;
        logic [7:0]  sel;
        logic [2:0]  ereq;
        logic [7:0]  ev;
        logic        evld;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 64;
    localparam vec_t VECS [NV] = '{
        // R2 program an unprotected sector
        '{OP_W, 12'h555, 8'hAA, 8'h01, RQ_N,  8'h00, 1'b0, 4'd2},
        '{OP_W, 12'hAAA, 8'h55, 8'h01, RQ_N,  8'h00, 1'b0, 4'd2},
        '{OP_W, 12'h555, 8'hA0, 8'h01, RQ_N,  8'h00, 1'b0, 4'd2},
        '{OP_W, 12'h123, 8'h3C, 8'h04, RQ_PG, 8'h3C, 1'b0, 4'd2},
        // R3 first unlock one address off
        '{OP_W, 12'h554, 8'hAA, 8'h01, RQ_N,  8'h00, 1'b0, 4'd3},
        '{OP_W, 12'hAAA, 8'h55, 8'h01, RQ_N,  8'h00, 1'b0, 4'd3},
        '{OP_W, 12'h555, 8'hA0, 8'h01, RQ_N,  8'h00, 1'b0, 4'd3},
        '{OP_W, 12'h123, 8'h3C, 8'h04, RQ_N,  8'h00, 1'b0, 4'd3},
        // R3 second unlock byte wrong
        '{OP_W, 12'h555, 8'hAA, 8'h01, RQ_N,  8'h00, 1'b0, 4'd3},
        '{OP_W, 12'hAAA, 8'h56, 8'h01, RQ_N,  8'h00, 1'b0, 4'd3},
        '{OP_W, 12'h555, 8'hA0, 8'h01, RQ_N,  8'h00, 1'b0, 4'd3},
        '{OP_W, 12'h123, 8'h3C, 8'h04, RQ_N,  8'h00, 1'b0, 4'd3},
        // R4 enter query mode
        '{OP_W, 12'h555, 8'hAA, 8'h01, RQ_N,  8'h00, 1'b0, 4'd4},
        '{OP_W, 12'hAAA, 8'h55, 8'h01, RQ_N,  8'h00, 1'b0, 4'd4},
        '{OP_W, 12'h555, 8'h90, 8'h01, RQ_QY, 8'h00, 1'b0, 4'd4},
        // R5 identifier, protection of an open and a locked sector, other address
        '{OP_R, 12'h001, 8'h00, 8'h01, RQ_N,  8'hE7, 1'b1, 4'd5},
        '{OP_R, 12'h002, 8'h00, 8'h01, RQ_N,  8'h00, 1'b1, 4'd5},
        '{OP_R, 12'h002, 8'h00, 8'h80, RQ_N,  8'h01, 1'b1, 4'd5},
        '{OP_R, 12'h043, 8'h00, 8'h01, RQ_N,  8'h00, 1'b0, 4'd5},
        // R10 leave query mode, reads go quiet
        '{OP_W, 12'h000, 8'hF0, 8'h01, RQ_RT, 8'h00, 1'b0, 4'd10},
        '{OP_R, 12'h001, 8'h00, 8'h01, RQ_N,  8'h00, 1'b0, 4'd10},
        // R6 bulk erase skips protected sector 7
        '{OP_W, 12'h555, 8'hAA, 8'h01, RQ_N,  8'h00, 1'b0, 4'd6},
        '{OP_W, 12'hAAA, 8'h55, 8'h01, RQ_N,  8'h00, 1'b0, 4'd6},
        '{OP_W, 12'h555, 8'h80, 8'h01, RQ_N,  8'h00, 1'b0, 4'd6},
        '{OP_W, 12'h555, 8'hAA, 8'h01, RQ_N,  8'h00, 1'b0, 4'd6},
        '{OP_W, 12'hAAA, 8'h55, 8'h01, RQ_N,  8'h00, 1'b0, 4'd6},
        '{OP_W, 12'h555, 8'h10, 8'h01, RQ_BK, 8'h7F, 1'b0, 4'd6},
        // R7 R8 sector erase of sectors 1 and 3
        '{OP_W, 12'h555, 8'hAA, 8'h01, RQ_N,  8'h00, 1'b0, 4'd7},
        '{OP_W, 12'hAAA, 8'h55, 8'h01, RQ_N,  8'h00, 1'b0, 4'd7},
        '{OP_W, 12'h555, 8'h80, 8'h01, RQ_N,  8'h00, 1'b0, 4'd7},
        '{OP_W, 12'h555, 8'hAA, 8'h01, RQ_N,  8'h00, 1'b0, 4'd7},
        '{OP_W, 12'hAAA, 8'h55, 8'h01, RQ_N,  8'h00, 1'b0, 4'd7},
        '{OP_W, 12'h100, 8'h30, 8'h02, RQ_N,  8'h00, 1'b0, 4'd7},
        '{OP_W, 12'h200, 8'h30, 8'h08, RQ_N,  8'h00, 1'b0, 4'd8},
        '{OP_D, 12'd400, 8'h00, 8'h00, RQ_SE, 8'h0A, 1'b0, 4'd7},
        // R9 suspend, resume, reset, then suspend outside an erase
        '{OP_W, 12'h000, 8'hB0, 8'h01, RQ_SU, 8'h00, 1'b0, 4'd9},
        '{OP_W, 12'h000, 8'h30, 8'h01, RQ_RS, 8'h00, 1'b0, 4'd9},
        '{OP_W, 12'h000, 8'hF0, 8'h01, RQ_RT, 8'h00, 1'b0, 4'd10},
        '{OP_W, 12'h000, 8'hB0, 8'h01, RQ_N,  8'h00, 1'b0, 4'd9},
        // R12 sector erase aimed only at protected sector 7
        '{OP_W, 12'h555, 8'hAA, 8'h01, RQ_N,  8'h00, 1'b0, 4'd12},
        '{OP_W, 12'hAAA, 8'h55, 8'h01, RQ_N,  8'h00, 1'b0, 4'd12},
        '{OP_W, 12'h555, 8'h80, 8'h01, RQ_N,  8'h00, 1'b0, 4'd12},
        '{OP_W, 12'h555, 8'hAA, 8'h01, RQ_N,  8'h00, 1'b0, 4'd12},
        '{OP_W, 12'hAAA, 8'h55, 8'h01, RQ_N,  8'h00, 1'b0, 4'd12},
        '{OP_W, 12'h700, 8'h30, 8'h80, RQ_N,  8'h00, 1'b0, 4'd12},
        '{OP_D, 12'd400, 8'h00, 8'h00, RQ_N,  8'h00, 1'b0, 4'd12},
        // R12 program to protected sector 7
        '{OP_W, 12'h555, 8'hAA, 8'h01, RQ_N,  8'h00, 1'b0, 4'd12},
        '{OP_W, 12'hAAA, 8'h55, 8'h01, RQ_N,  8'h00, 1'b0, 4'd12},
        '{OP_W, 12'h555, 8'hA0, 8'h01, RQ_N,  8'h00, 1'b0, 4'd12},
        '{OP_W, 12'h010, 8'h11, 8'h80, RQ_N,  8'h00, 1'b0, 4'd12},
        // R12 no sector selected mid-prefix
        '{OP_W, 12'h555, 8'hAA, 8'h01, RQ_N,  8'h00, 1'b0, 4'd12},
        '{OP_W, 12'hAAA, 8'h55, 8'h00, RQ_N,  8'h00, 1'b0, 4'd12},
        '{OP_W, 12'h555, 8'hA0, 8'h01, RQ_N,  8'h00, 1'b0, 4'd12},
        '{OP_W, 12'h010, 8'h11, 8'h01, RQ_N,  8'h00, 1'b0, 4'd12},
        // R11 gap longer than the timeout
        '{OP_W, 12'h555, 8'hAA, 8'h01, RQ_N,  8'h00, 1'b0, 4'd11},
        '{OP_W, 12'hAAA, 8'h55, 8'h01, RQ_N,  8'h00, 1'b0, 4'd11},
        '{OP_D, 12'd500, 8'h00, 8'h00, RQ_N,  8'h00, 1'b0, 4'd11},
        '{OP_W, 12'h555, 8'hA0, 8'h01, RQ_N,  8'h00, 1'b0, 4'd11},
        '{OP_W, 12'h010, 8'h22, 8'h02, RQ_N,  8'h00, 1'b0, 4'd11},
        // R11 gap shorter than the timeout
        '{OP_W, 12'h555, 8'hAA, 8'h01, RQ_N,  8'h00, 1'b0, 4'd11},
        '{OP_W, 12'hAAA, 8'h55, 8'h01, RQ_N,  8'h00, 1'b0, 4'd11},
        '{OP_D, 12'd300, 8'h00, 8'h00, RQ_N,  8'h00, 1'b0, 4'd11},
        '{OP_W, 12'h555, 8'hA0, 8'h01, RQ_N,  8'h00, 1'b0, 4'd11},
        '{OP_W, 12'h020, 8'h44, 8'h02, RQ_PG, 8'h44, 1'b0, 4'd11}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr_lo = '0;
    logic [7:0]  sec_sel = '0;
    logic [7:0]  sec_prot = 8'h80;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        us_tick = 1'b0;
    logic        req_prog, req_bulk, req_sect, req_susp, req_resume, req_reset, req_query;
    logic [11:0] req_addr;
    logic [7:0]  req_data;
    logic [7:0]  req_sectors;
    logic [7:0]  rd_data;
    logic        rd_vld;

    int nvec = 0;
    int nmis = 0;
    int cnt [8];
    int rd_cnt;
    logic [11:0] cap_addr;
    logic [7:0]  cap_data;
    logic [7:0]  cap_secs;
    logic [7:0]  rd_last;
    int tick_cnt = 0;
    bit done = 1'b0;

    fcmd_decoder u_dut (
        .clk (clk), .rst_n (rst_n), .addr_lo (addr_lo), .sec_sel (sec_sel),
        .sec_prot (sec_prot), .wdata (wdata), .wr_en (wr_en), .rd_en (rd_en),
        .us_tick (us_tick), .req_prog (req_prog), .req_bulk (req_bulk),
        .req_sect (req_sect), .req_susp (req_susp), .req_resume (req_resume),
        .req_reset (req_reset), .req_query (req_query), .req_addr (req_addr),
        .req_data (req_data), .req_sectors (req_sectors), .rd_data (rd_data),
        .rd_vld (rd_vld)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
        us_tick  <= (tick_cnt == TICK_DIV - 1);
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (req_prog)   cnt[1] = cnt[1] + 1;
            if (req_bulk)   cnt[2] = cnt[2] + 1;
            if (req_sect)   cnt[3] = cnt[3] + 1;
            if (req_susp)   cnt[4] = cnt[4] + 1;
            if (req_resume) cnt[5] = cnt[5] + 1;
            if (req_reset)  cnt[6] = cnt[6] + 1;
            if (req_query)  cnt[7] = cnt[7] + 1;
            if (req_prog || req_bulk || req_sect) begin
                cap_addr = req_addr;
                cap_data = req_data;
                cap_secs = req_sectors;
            end
            if (rd_vld) begin
                rd_cnt  = rd_cnt + 1;
                rd_last = rd_data;
            end
        end
    end

    function automatic vec_t wv(input logic [11:0] a, input logic [7:0] d,
                                input logic [7:0] s, input logic [2:0] e,
                                input logic [7:0] v, input logic [3:0] r);
        vec_t t;
        t = '{OP_W, a, d, s, e, v, 1'b0, r};
        return t;
    endfunction

    task automatic clear_counts();
        for (int k = 0; k < 8; k++) cnt[k] = 0;
        rd_cnt = 0;
    endtask

    task automatic apply(input vec_t v, input int idx);
        bit ok;
        ok = 1'b1;
        clear_counts();
        if (v.op == OP_W || v.op == OP_R) begin
            @(negedge clk);
            addr_lo = v.addr;
            wdata   = v.data;
            sec_sel = v.sel;
            wr_en   = (v.op == OP_W);
            rd_en   = (v.op == OP_R);
            @(negedge clk);
            wr_en = 1'b0;
            rd_en = 1'b0;
            repeat (5) @(negedge clk);
        end else begin
            repeat (int'(v.addr)) @(negedge clk);
        end
        for (int k = 1; k < 8; k++) begin
            if (cnt[k] != ((int'(v.ereq) == k) ? 1 : 0)) begin
                $display("FAIL R%0d vec %0d: request code %0d pulses got %0d exp %0d",
                         v.rq, idx, k, cnt[k], (int'(v.ereq) == k) ? 1 : 0);
                ok = 1'b0;
            end
        end
        if (v.ereq == RQ_PG && cnt[1] == 1) begin
            if (cap_addr != v.addr || cap_data != v.ev || cap_secs != v.sel) begin
                $display("FAIL R%0d vec %0d: prog addr/data/secs got %h/%h/%h exp %h/%h/%h",
                         v.rq, idx, cap_addr, cap_data, cap_secs, v.addr, v.ev, v.sel);
                ok = 1'b0;
            end
        end
        if ((v.ereq == RQ_BK && cnt[2] == 1) || (v.ereq == RQ_SE && cnt[3] == 1)) begin
            if (cap_secs != v.ev) begin
                $display("FAIL R%0d vec %0d: sectors got %h exp %h", v.rq, idx, cap_secs, v.ev);
                ok = 1'b0;
            end
        end
        if (v.op == OP_R) begin
            if (rd_cnt != (v.evld ? 1 : 0)) begin
                $display("FAIL R%0d vec %0d: read responses got %0d exp %0d",
                         v.rq, idx, rd_cnt, v.evld ? 1 : 0);
                ok = 1'b0;
            end else if (v.evld && rd_last != v.ev) begin
                $display("FAIL R%0d vec %0d: read data got %h exp %h", v.rq, idx, rd_last, v.ev);
                ok = 1'b0;
            end
        end
        nvec = nvec + 1;
        if (!ok) nmis = nmis + 1;
    endtask

    initial begin
        for (int k = 0; k < 8; k++) cnt[k] = 0;
        rd_cnt = 0;
        // R1 outputs quiet while reset is held
        repeat (4) @(negedge clk);
        nvec = nvec + 1;
        if ({req_prog, req_bulk, req_sect, req_susp, req_resume, req_reset, req_query, rd_vld} != 8'h00) begin
            $display("FAIL R1 reset: outputs got %b exp 00000000",
                     {req_prog, req_bulk, req_sect, req_susp, req_resume, req_reset, req_query, rd_vld});
            nmis = nmis + 1;
        end
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int i = 0; i < NV; i++) apply(VECS[i], i);

        // R1 a reset in mid-sequence drops it
        apply(wv(12'h555, 8'hAA, 8'h01, RQ_N, 8'h00, 4'd1), 100);
        apply(wv(12'hAAA, 8'h55, 8'h01, RQ_N, 8'h00, 4'd1), 101);
        apply(wv(12'h555, 8'hA0, 8'h01, RQ_N, 8'h00, 4'd1), 102);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        apply(wv(12'h010, 8'h5A, 8'h02, RQ_N, 8'h00, 4'd1), 103);

        // R8 a confirmation after the window closed does not join the erase
        apply(wv(12'h555, 8'hAA, 8'h01, RQ_N, 8'h00, 4'd8), 110);
        apply(wv(12'hAAA, 8'h55, 8'h01, RQ_N, 8'h00, 4'd8), 111);
        apply(wv(12'h555, 8'h80, 8'h01, RQ_N, 8'h00, 4'd8), 112);
        apply(wv(12'h555, 8'hAA, 8'h01, RQ_N, 8'h00, 4'd8), 113);
        apply(wv(12'hAAA, 8'h55, 8'h01, RQ_N, 8'h00, 4'd8), 114);
        apply(wv(12'h100, 8'h30, 8'h02, RQ_N, 8'h00, 4'd8), 115);
        apply('{OP_D, 12'd400, 8'h00, 8'h00, RQ_SE, 8'h02, 1'b0, 4'd8}, 116);
        apply(wv(12'h200, 8'h30, 8'h04, RQ_N, 8'h00, 4'd8), 117);
        apply(wv(12'h000, 8'hB0, 8'h01, RQ_N, 8'h00, 4'd8), 118);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nmis = nmis + 1;
            $display("FAIL watchdog: cycles got 200000 exp fewer");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
            $finish;
        end
    end

endmodule